// File: doc/BRIEF.md
# PHY Reset and Power-Down Controller

This block sits beside the management register file of a two-port Ethernet PHY and decides when each port's control register may be touched, what values it holds after each kind of reset, and whether the port's data-side outputs are driven. It accepts a level-sensitive hardware reset request, per-port power-down pins and one global power-down pin. Each port's control register carries a self-clearing software reset bit and a software power-down bit.

During hardware reset the configuration straps of each port (auto-negotiation enable, speed, duplex) are copied into the control register and into a per-port snapshot. A software reset, or the release of a power-down pin, never looks at the straps again. Instead it restores the three configuration bits from that snapshot. After hardware reset ends, all register access stays blocked for one millisecond. The length of that window comes from the clock-frequency parameter.

Access goes through a plain parallel port. The address selects a port and a register index. Reads are combinational and carry a ready flag. Writes take effect at the next clock edge. Only register index 0, the control register, holds state.

Top module: `phy_rst_pwr_ctrl`

## Requirements
- R1: While `hw_rst` is high, each port samples its strap triple (`strap[3p+2]` auto-negotiation, `strap[3p+1]` speed, `strap[3p]` duplex) into control bits 13, 12 and 8, into `cfg_bits` (same layout) and into its snapshot. It also clears bit 11 and any software reset in progress.
- R2: Access to both ports stays blocked while `hw_rst` is high and for LOCK_CYC = CLK_HZ/1000 cycles after it falls. A blocked read returns 16'hFFFF with `ready` low, and a blocked write is ignored.
- R3: A write of a word with bit 15 set to control register 0 of an unblocked, idle port starts a software reset. Bit 15 then reads 1 for exactly SWR_CYC cycles and 0 afterwards. Bits 13, 12 and 8 take the snapshot values and bit 11 clears.
- R4: A software reset does not re-sample the straps: strap changes made since the last hardware reset have no effect on the register or on `cfg_bits`.
- R5: During a software reset the port stays readable with `ready` high, and writes to it are ignored.
- R6: Bit 11 set to 1 powers the port down: its `data_oe` bit goes low, its register stays accessible, and bits 13, 12 and 8 keep their values.
- R7: While `hw_pd[p]` is high, port p has `data_oe[p]` low and blocked access (16'hFFFF, `ready` low, writes ignored). The other port is unaffected.
- R8: While `glb_pd` is high, both ports behave as in R7.
- R9: In the first cycle after a port's power-down input (its pin or `glb_pd`) is released, bits 13, 12 and 8 reload from the snapshot, bit 11 clears and any write in that cycle is ignored. The straps are not read.
- R10: `data_oe[p]` is high only when `hw_rst` is low, port p is not powered down by a pin and its bit 11 is 0.
- R11: In control register 0, bits 15, 13, 12, 11 and 8 are defined and every other bit reads 0. Register indices 1 to 31 read 0 with `ready` high, and writes to them change nothing.
- R12: Each port holds its own register and snapshot. A write addressed to one port (address bit 5) leaves the other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_rst | input | 1 | Active-high hardware reset request, synchronous level |
| strap | input | 3*NPORT | Configuration straps, three per port |
| hw_pd | input | NPORT | Per-port power-down pins, active high |
| glb_pd | input | 1 | Global power-down pin, active high |
| addr | input | ADDR_W | {port select, register index[4:0]} |
| wdata | input | 16 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 16 | Read data, combinational |
| ready | output | 1 | High when the addressed port accepts access |
| data_oe | output | NPORT | Data-interface output enable per port |
| cfg_bits | output | 3*NPORT | Current configuration triple per port |

## Verification
The assertions assume that `rst_n` is asserted at least once before any check counts. They also assume that `hw_rst`, the straps and the power-down pins change only away from the rising edge and stay stable across it. The bench drives every input at the falling edge and holds `hw_rst` high through the release of `rst_n`, so the first state the checks see is a sampled one. Random stimulus sets `hw_rst` for short bursts and toggles the power-down pins rarely. The lock window, software resets and releases therefore all complete inside the run.

// File: rtl/phy_rpc_pkg.sv
package phy_rpc_pkg;
  localparam int BIT_SWR = 15;
  localparam int BIT_AN  = 13;
  localparam int BIT_SPD = 12;
  localparam int BIT_PD  = 11;
  localparam int BIT_DUP = 8;
  localparam int REG_W   = 16;
  localparam int IDX_W   = 5;

  typedef struct packed {
    logic an;
    logic spd;
    logic dup;
  } strap_t;
endpackage

// File: rtl/rpc_lock_timer.sv
module rpc_lock_timer #(
  parameter int LOCK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = hw_rst || (cnt_q != '0);
    cnt_d  = hw_rst ? CW'(LOCK_CYC) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(LOCK_CYC);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_rst) |-> busy);
  // R2
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_rst && !busy) |=> !busy);
endmodule

// File: rtl/rpc_port_regs.sv
module rpc_port_regs
  import phy_rpc_pkg::*;
#(
  parameter int SWR_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             hw_pd,
  input  strap_t           strap,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_rd,
  output strap_t           cfg,
  output logic             pd_bit
);
  localparam int CW = $clog2(SWR_CYC > 1 ? SWR_CYC : 2);

  strap_t        cfg_q, cfg_d, snap_q, snap_d;
  logic          pd_q, pd_d, busy_q, busy_d, pdq_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cfg_d  = cfg_q;
    snap_d = snap_q;
    pd_d   = pd_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (hw_rst) begin
      cfg_d  = strap;
      snap_d = strap;
      pd_d   = 1'b0;
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (hw_pd) begin
      busy_d = 1'b0;
    end else if (pdq_q) begin
      cfg_d  = snap_q;
      pd_d   = 1'b0;
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (wr_en) begin
      if (wdata[BIT_SWR]) begin
        busy_d = 1'b1;
        cnt_d  = CW'(SWR_CYC - 1);
        cfg_d  = snap_q;
        pd_d   = 1'b0;
      end else begin
        cfg_d = '{an: wdata[BIT_AN], spd: wdata[BIT_SPD], dup: wdata[BIT_DUP]};
        pd_d  = wdata[BIT_PD];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      snap_q <= '0;
      pd_q   <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pdq_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      snap_q <= snap_d;
      pd_q   <= pd_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      pdq_q  <= hw_pd;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[BIT_SWR] = busy_q;
    ctrl_rd[BIT_AN]  = cfg_q.an;
    ctrl_rd[BIT_SPD] = cfg_q.spd;
    ctrl_rd[BIT_PD]  = pd_q;
    ctrl_rd[BIT_DUP] = cfg_q.dup;
  end

  assign cfg    = cfg_q;
  assign pd_bit = pd_q;

  // R1
  strap_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (cfg_q == $past(strap)) && (snap_q == $past(strap)) && !pd_q);
  // R3
  swr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cfg_q == snap_q) && !pd_q);
  // R9
  pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_rst && !hw_pd && pdq_q) |=> (cfg_q == snap_q) && !pd_q && !busy_q);
  // R5
  swr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !hw_rst && !hw_pd && !pdq_q) |=> $stable(cfg_q) && $stable(pd_q));
endmodule

// File: rtl/phy_rst_pwr_ctrl.sv
module phy_rst_pwr_ctrl
  import phy_rpc_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int CLK_HZ  = 25_000_000,
  parameter int SWR_CYC = 16,
  parameter int PSEL_W  = (NPORT > 1) ? $clog2(NPORT) : 1,
  parameter int ADDR_W  = PSEL_W + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hw_rst,
  input  logic [3*NPORT-1:0]   strap,
  input  logic [NPORT-1:0]     hw_pd,
  input  logic                 glb_pd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 we,
  output logic [REG_W-1:0]     rdata,
  output logic                 ready,
  output logic [NPORT-1:0]     data_oe,
  output logic [3*NPORT-1:0]   cfg_bits
);
  localparam int LOCK_RAW = CLK_HZ / 1000;
  localparam int LOCK_CYC = (LOCK_RAW > 0) ? LOCK_RAW : 1;

  logic              lock_busy;
  logic [PSEL_W-1:0] sel;
  logic [IDX_W-1:0]  ridx;
  logic [NPORT-1:0]  port_pd, blocked, wr_en, pd_bit;
  logic [REG_W-1:0]  ctrl_rd [NPORT];

  assign sel  = addr[ADDR_W-1:IDX_W];
  assign ridx = addr[IDX_W-1:0];

  rpc_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_rst (hw_rst),
    .busy   (lock_busy)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    strap_t strap_p, cfg_p;

    assign strap_p    = strap[3*p +: 3];
    assign port_pd[p] = hw_pd[p] | glb_pd;
    assign blocked[p] = hw_rst | lock_busy | port_pd[p];
    assign wr_en[p]   = we && (sel == PSEL_W'(p)) && (ridx == '0) && !blocked[p];
    assign data_oe[p] = !hw_rst && !port_pd[p] && !pd_bit[p];
    assign cfg_bits[3*p +: 3] = cfg_p;

    rpc_port_regs #(.SWR_CYC(SWR_CYC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_rst  (hw_rst),
      .hw_pd   (port_pd[p]),
      .strap   (strap_p),
      .wr_en   (wr_en[p]),
      .wdata   (wdata),
      .ctrl_rd (ctrl_rd[p]),
      .cfg     (cfg_p),
      .pd_bit  (pd_bit[p])
    );
  end

  always_comb begin
    ready = 1'b1;
    rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (sel == PSEL_W'(p)) begin
        if (blocked[p]) begin
          ready = 1'b0;
          rdata = '1;
        end else if (ridx == '0) begin
          rdata = ctrl_rd[p];
        end
      end
    end
  end

  // R2
  lock_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_rst) |-> !ready && (rdata == '1));
  // R10
  oe_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |-> (data_oe == '0));
  // R8
  glb_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_pd |-> !ready && (data_oe == '0));
endmodule

// File: tb/phy_rst_pwr_ctrl_tb.sv
module phy_rst_pwr_ctrl_tb;
  localparam int PERIOD  = 10;
  localparam int NP      = 2;
  localparam int CLK_HZ  = 20000;
  localparam int LOCK    = CLK_HZ / 1000;
  localparam int SWR     = 16;

  logic        clk = 1'b0;
  logic        rst_n, hw_rst, glb_pd, we;
  logic [5:0]  strap;
  logic [1:0]  hw_pd;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        ready;
  logic [1:0]  data_oe;
  logic [5:0]  cfg_bits;

  int n_chk = 0;
  int n_bad = 0;

  logic [2:0] m_cfg [NP];
  logic [2:0] m_snap[NP];
  logic       m_pd  [NP];
  logic       m_pdq [NP];
  int         m_swr [NP];
  int         m_lock;

  always #(PERIOD/2) clk = ~clk;

  phy_rst_pwr_ctrl #(.NPORT(NP), .CLK_HZ(CLK_HZ), .SWR_CYC(SWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .strap(strap), .hw_pd(hw_pd),
    .glb_pd(glb_pd), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .ready(ready), .data_oe(data_oe), .cfg_bits(cfg_bits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ctrl_val(input int p);
    logic [15:0] v = '0;
    v[15] = (m_swr[p] > 0);
    v[13] = m_cfg[p][2];
    v[12] = m_cfg[p][1];
    v[11] = m_pd[p];
    v[8]  = m_cfg[p][0];
    return v;
  endfunction

  function automatic logic port_blk(input int p);
    return hw_rst || (m_lock > 0) || glb_pd || hw_pd[p];
  endfunction

  task automatic compare(input string tag);
    int s = int'(addr[5]);
    logic blk = port_blk(s);
    logic [15:0] er = blk ? 16'hFFFF : (addr[4:0] != 0 ? 16'h0 : ctrl_val(s));
    chk({tag, " ready R2/R7"}, 32'(ready), 32'(!blk));
    chk({tag, " rdata R11"}, 32'(rdata), 32'(er));
    for (int p = 0; p < NP; p++) begin
      chk({tag, " oe R10"}, 32'(data_oe[p]),
          32'(!hw_rst && !(glb_pd || hw_pd[p]) && !m_pd[p]));
      chk({tag, " cfg R1"}, 32'(cfg_bits[3*p +: 3]), 32'(m_cfg[p]));
    end
  endtask

  task automatic upd();
    int  s   = int'(addr[5]);
    logic acc = we && !port_blk(s) && (addr[4:0] == 0);
    for (int p = 0; p < NP; p++) begin
      logic hp = glb_pd || hw_pd[p];
      if (hw_rst) begin
        m_cfg[p] = strap[3*p +: 3]; m_snap[p] = strap[3*p +: 3];
        m_pd[p] = 1'b0; m_swr[p] = 0;
      end else if (hp) begin
        m_swr[p] = 0;
      end else if (m_pdq[p]) begin
        m_cfg[p] = m_snap[p]; m_pd[p] = 1'b0; m_swr[p] = 0;
      end else if (m_swr[p] > 0) begin
        m_swr[p]--;
      end else if (acc && s == p) begin
        if (wdata[15]) begin
          m_swr[p] = SWR; m_cfg[p] = m_snap[p]; m_pd[p] = 1'b0;
        end else begin
          m_cfg[p] = {wdata[13], wdata[12], wdata[8]}; m_pd[p] = wdata[11];
        end
      end
      m_pdq[p] = hp;
    end
    if (hw_rst) m_lock = LOCK;
    else if (m_lock > 0) m_lock--;
  endtask

  task automatic tick(input string tag);
    #1; compare(tag);
    @(posedge clk); upd();
    @(negedge clk);
  endtask

  task automatic acc(input logic w, input int p, input int r, input logic [15:0] d);
    we = w; addr = {1'(p), 5'(r)}; wdata = d;
  endtask

  task automatic peek(input string req, input int p, input logic [15:0] exp);
    acc(1'b0, p, 0, 16'h0); #1;
    chk(req, 32'(rdata), 32'(exp));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int hold;
    rst_n = 1'b0; hw_rst = 1'b1; glb_pd = 1'b0; hw_pd = '0;
    strap = 6'b010_101; we = 1'b0; addr = '0; wdata = '0;
    for (int p = 0; p < NP; p++) begin
      m_cfg[p] = '0; m_snap[p] = '0; m_pd[p] = 0; m_pdq[p] = 0; m_swr[p] = 0;
    end
    m_lock = LOCK;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick("R1 hwrst");
    #1;
    chk("R1 blocked ready", 32'(ready), 32'h0);
    chk("R1 blocked rdata", 32'(rdata), 32'hFFFF);
    chk("R10 oe in reset", 32'(data_oe), 32'h0);
    chk("R1 straps", 32'(cfg_bits), 32'(6'b010_101));

    hw_rst = 1'b0; strap = 6'b111_000;
    acc(1'b1, 0, 0, 16'h0800);
    for (int i = 0; i < LOCK; i++) tick("R2 lock");
    acc(1'b0, 0, 0, 16'h0); #1;
    chk("R2 ready after lock", 32'(ready), 32'h1);
    chk("R2 write ignored", 32'(rdata), 32'h2100);
    chk("R10 oe released", 32'(data_oe), 32'h3);

    acc(1'b1, 0, 0, 16'h7FFF); tick("R11 wr");
    peek("R11 defined bits", 0, 16'h3900);
    chk("R6 oe off by bit", 32'(data_oe), 32'h2);
    chk("R6 still ready", 32'(ready), 32'h1);
    acc(1'b1, 0, 5, 16'hFFFF); tick("R11 other reg");
    acc(1'b0, 0, 5, 16'h0); #1;
    chk("R11 other reg zero", 32'(rdata), 32'h0);
    peek("R11 reg0 untouched", 0, 16'h3900);
    peek("R12 other port", 1, 16'h1000);

    acc(1'b1, 0, 0, 16'h8000); tick("R3 start");
    peek("R3 busy bit", 0, 16'hA100);
    chk("R5 ready in swr", 32'(ready), 32'h1);
    chk("R4 no resample", 32'(cfg_bits[2:0]), 32'(3'b101));
    acc(1'b1, 0, 0, 16'h0800);
    for (int i = 0; i < SWR; i++) tick("R3 swr");
    peek("R3 self clear and R5 write ignored", 0, 16'h2100);

    acc(1'b1, 1, 0, 16'h2900); tick("R12 wr p1");
    hw_pd = 2'b10; acc(1'b0, 1, 0, 16'h0); #1;
    chk("R7 p1 blocked", 32'(ready), 32'h0);
    acc(1'b1, 1, 0, 16'h3100); tick("R7 pd");
    peek("R7 p0 free", 0, 16'h2100);
    chk("R7 p0 ready", 32'(ready), 32'h1);
    chk("R7 oe", 32'(data_oe), 32'h1);
    hw_pd = 2'b00; acc(1'b1, 1, 0, 16'h3100); tick("R9 release");
    peek("R9 reload snapshot", 1, 16'h1000);

    glb_pd = 1'b1; acc(1'b0, 0, 0, 16'h0); #1;
    chk("R8 p0 blocked", 32'(ready), 32'h0);
    chk("R8 oe off", 32'(data_oe), 32'h0);
    tick("R8 glb"); glb_pd = 1'b0; tick("R9 glb rel");

    hw_rst = 1'b1; repeat (2) tick("R1 again"); hw_rst = 1'b0;
    #1; chk("R1 new straps", 32'(cfg_bits), 32'(6'b111_000));
    for (int i = 0; i < LOCK; i++) tick("R2 lock2");

    void'($urandom(32'd2024));
    hold = 0;
    for (int i = 0; i < 3000; i++) begin
      if (hold > 0) begin hold--; hw_rst = (hold > 0); end
      else if ($urandom_range(0, 299) == 0) begin hold = $urandom_range(1, 4); hw_rst = 1'b1; end
      if ($urandom_range(0, 39) == 0) hw_pd[$urandom_range(0, 1)] ^= 1'b1;
      if ($urandom_range(0, 99) == 0) glb_pd = ~glb_pd;
      if ($urandom_range(0, 29) == 0) strap = 6'($urandom);
      acc(1'($urandom), int'($urandom_range(0, 1)),
          ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 31)) : 0,
          {($urandom_range(0, 7) == 0), 15'($urandom)});
      tick("rand R12");
    end
    summary();
  end
endmodule